// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block is the digital sequencer for a 10-bit successive-approximation converter. It accepts a start request from one of four sources, chosen by a mode field. It times the conversion with a divided clock and keeps a busy flag high for the whole conversion. While busy, it presents each trial code to the analog comparator and resolves the result one bit at a time, MSB first. When busy falls, a sticky completion flag is set. If the interrupt is enabled, the interrupt output is driven.

Software reaches the block through a small byte-wide register port with four addresses. Address 0 is control and status, address 1 sets the conversion-clock divider, and addresses 2 and 3 return the high and low bytes of the result. The result can be read left- or right-justified within the 16-bit byte pair. The expected flow is to clear the completion flag, start a conversion, poll the flag until it reads 1, then read the two result bytes.

Top module: `adc_soc_ctrl`

## Requirements
- R1: Control bits 5:4 select the start source: 00 = software write of 1 to control bit 0, 01 = `tmr3_ovf` pulse, 10 = rising edge of `ext_start`, 11 = `tmr2_ovf` pulse. Events from the other three sources do not start a conversion.
- R2: Busy (control bit 0) reads 1 for exactly 11*(D+1) system clock cycles per conversion, where D is the divider field in bits DIV_W-1:0 of address 1. This is one tracking period plus one decision per result bit, each lasting D+1 cycles.
- R3: The completion flag (control bit 1) is set in the same cycle that busy falls and stays set. A register write to address 0 with bit 1 = 0 clears it, and a write with bit 1 = 1 leaves it unchanged.
- R4: `irq` is 1 exactly when the completion flag and the interrupt enable (control bit 2) are both 1.
- R5: The result equals the value resolved MSB first from `cmp_in`. Each decision keeps the trial bit when `cmp_in` is 1. `dac_code` shows the current trial code, so an ideal comparator yields its input value.
- R6: Control bit 3 = 1 places the result in bits 15:6 of the {address 2, address 3} pair with the low 6 bits zero. Bit 3 = 0 places it in bits 9:0 with the upper 6 bits zero.
- R7: `ext_start` passes through a two-flop synchroniser, and only a 0-to-1 transition starts a conversion. A level held high does not start another one.
- R8: Start events that arrive while busy is 1 are ignored and do not lengthen the conversion.
- R9: The stored result changes only in the cycle busy falls and holds its value throughout a conversion.
- R10: Synchronous reset clears busy, the completion flag, the interrupt enable, justification, divider and result, and sets the mode to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tmr3_ovf | input | 1 | First timer overflow strobe |
| tmr2_ovf | input | 1 | Second timer overflow strobe |
| ext_start | input | 1 | Asynchronous external convert-start pin |
| cmp_in | input | 1 | Comparator decision from the analog macro |
| dac_code | output | RES_W | Trial code presented to the analog macro |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with DIV_W = 4 and RES_W = 10. It sweeps divider values from 0 up to 15, which reaches both the single-cycle decision path and long conversion-clock periods within a short run. The 10-bit width makes the two justification layouts and the all-zero and all-one results at the range ends directly checkable. An ideal comparator driven from `dac_code` makes every expected result equal to the chosen input value.

// File: rtl/adc_soc_pkg.sv
package adc_soc_pkg;
  typedef enum logic [1:0] {
    SRC_SW  = 2'b00,
    SRC_T3  = 2'b01,
    SRC_EXT = 2'b10,
    SRC_T2  = 2'b11
  } src_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_LO   = 2'd3;
endpackage

// File: rtl/adc_start_sel.sv
module adc_start_sel
  import adc_soc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  src_e mode,
  input  logic sw_go,
  input  logic t3_ovf,
  input  logic t2_ovf,
  input  logic ext_pin,
  output logic start
);
  // sync chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh;
  logic ext_rise;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], ext_pin};
  end

  assign ext_rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  always_comb begin
    unique case (mode)
      SRC_SW:  start = sw_go;
      SRC_T3:  start = t3_ovf;
      SRC_EXT: start = ext_rise;
      SRC_T2:  start = t2_ovf;
      default: start = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = ~clr & (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             cmp,
  output logic             busy,
  output logic             finish,
  output logic [RES_W-1:0] dac,
  output logic [RES_W-1:0] result
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic             tracking;
  logic [RES_W-1:0] sar, mask, decided;

  assign decided = cmp ? sar : (sar & ~mask);
  assign finish  = busy & tick & ~tracking & mask[0];
  assign dac     = sar;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tracking <= 1'b0;
      sar      <= '0;
      mask     <= '0;
      result   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        tracking <= 1'b1;
        sar      <= '0;
        mask     <= '0;
      end
    end else if (tick) begin
      if (tracking) begin
        tracking <= 1'b0;
        sar      <= MSB;
        mask     <= MSB;
      end else if (mask[0]) begin
        result <= decided;
        sar    <= decided;
        busy   <= 1'b0;
      end else begin
        sar  <= decided | (mask >> 1);
        mask <= mask >> 1;
      end
    end
  end
endmodule

// File: rtl/adc_soc_ctrl.sv
module adc_soc_ctrl
  import adc_soc_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             tmr3_ovf,
  input  logic             tmr2_ovf,
  input  logic             ext_start,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             irq
);
  localparam int PAD = 16 - RES_W;

  src_e             mode_q;
  logic             ien_q, ljust_q, done_q;
  logic [DIV_W-1:0] div_q;
  logic             busy_w, finish_w, start_w, tick_w, sw_go;
  logic [RES_W-1:0] res_w;
  logic [15:0]      packed_res;
  logic             ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign sw_go   = ctrl_wr & reg_wdata[0];

  adc_start_sel #(.SYNC_STAGES(2)) u_sel (
    .clk(clk), .rst(rst), .mode(mode_q), .sw_go(sw_go),
    .t3_ovf(tmr3_ovf), .t2_ovf(tmr2_ovf), .ext_pin(ext_start),
    .start(start_w)
  );

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(~busy_w), .div(div_q), .tick(tick_w)
  );

  adc_sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst(rst), .start(start_w), .tick(tick_w), .cmp(cmp_in),
    .busy(busy_w), .finish(finish_w), .dac(dac_code), .result(res_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SRC_SW;
      ien_q   <= 1'b0;
      ljust_q <= 1'b0;
      div_q   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        mode_q  <= src_e'(reg_wdata[5:4]);
        ljust_q <= reg_wdata[3];
        ien_q   <= reg_wdata[2];
      end else if (reg_addr == A_CFG) begin
        div_q <= reg_wdata[DIV_W-1:0];
      end
    end
  end

  // completion flag: set beats a simultaneous software clear
  always_ff @(posedge clk) begin
    if (rst)                          done_q <= 1'b0;
    else if (finish_w)                done_q <= 1'b1;
    else if (ctrl_wr && !reg_wdata[1]) done_q <= 1'b0;
  end

  assign irq = done_q & ien_q;

  assign packed_res = ljust_q ? {res_w, {PAD{1'b0}}} : {{PAD{1'b0}}, res_w};

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, mode_q, ljust_q, ien_q, done_q, busy_w};
      A_CFG:   reg_rdata = {{(8-DIV_W){1'b0}}, div_q};
      A_HI:    reg_rdata = packed_res[15:8];
      default: reg_rdata = packed_res[7:0];
    endcase
  end
endmodule

// File: rtl/adc_soc_ctrl_chk.sv
module adc_soc_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             ien,
  input logic             irq,
  input logic [1:0]       mode,
  input logic [RES_W-1:0] res
);
  a_r3_fall_sets_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r4_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($fell(busy) || $rose(ien)));

  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(res));

  a_r2_busy_spans: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !irq && mode == 2'b00 && res == '0));
endmodule

bind adc_soc_ctrl adc_soc_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_w), .done(done_q), .ien(ien_q),
  .irq(irq), .mode(mode_q), .res(res_w)
);

// File: tb/adc_soc_ctrl_bench.sv
module adc_soc_ctrl_bench;
  localparam int DIV_W = 4;
  localparam int RES_W = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst, reg_wr, tmr3_ovf, tmr2_ovf, ext_start, cmp_in, irq;
  logic [1:0]       reg_addr;
  logic [7:0]       reg_wdata, reg_rdata;
  logic [RES_W-1:0] dac_code, vin;
  int checks = 0, errors = 0;

  assign cmp_in = (vin >= dac_code);

  adc_soc_ctrl #(.DIV_W(DIV_W), .RES_W(RES_W)) u_adc_soc_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr3_ovf(tmr3_ovf),
    .tmr2_ovf(tmr2_ovf), .ext_start(ext_start), .cmp_in(cmp_in),
    .dac_code(dac_code), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_hi(input logic [RES_W-1:0] v, input bit lj);
    logic [15:0] w;
    w = lj ? {v, 6'b0} : {6'b0, v};
    return w[15:8];
  endfunction

  function automatic logic [7:0] exp_lo(input logic [RES_W-1:0] v, input bit lj);
    logic [15:0] w;
    w = lj ? {v, 6'b0} : {6'b0, v};
    return w[7:0];
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raise a start event for the given source; returns on a falling clock edge
  task automatic fire(input logic [1:0] src, input logic [7:0] ctrl);
    case (src)
      2'b00: wr(2'd0, ctrl | 8'h03);
      2'b01: begin @(negedge clk); tmr3_ovf = 1'b1; @(negedge clk); tmr3_ovf = 1'b0; end
      2'b10: begin @(negedge clk); ext_start = 1'b1; end
      default: begin @(negedge clk); tmr2_ovf = 1'b1; @(negedge clk); tmr2_ovf = 1'b0; end
    endcase
  endtask

  task automatic conv(input logic [1:0] src, input int d, input logic [RES_W-1:0] v,
                      input bit lj, input bit ie, input bit mid_retrigger);
    logic [7:0] ctrl, r, hi0, lo0;
    int n, w;
    vin  = v;
    ctrl = {2'b00, src, lj, ie, 2'b00};
    wr(2'd1, 8'(d));
    wr(2'd0, ctrl);
    rd(2'd2, hi0); rd(2'd3, lo0);
    fire(src, ctrl);
    w = 0; rd(2'd0, r);
    while (!r[0] && w < 10) begin @(negedge clk); w++; rd(2'd0, r); end
    n = 0;
    while (r[0] && n < 400) begin
      n++;
      if (mid_retrigger && n == 3) begin
        // R8: a second event during the conversion
        if (src == 2'b01) tmr3_ovf = 1'b1; else if (src == 2'b11) tmr2_ovf = 1'b1;
        else if (src == 2'b00) begin reg_wr = 1'b1; reg_wdata = ctrl | 8'h03; end
      end
      if (n == 4) begin
        tmr3_ovf = 1'b0; tmr2_ovf = 1'b0; reg_wr = 1'b0;
        rd(2'd2, r); chk(r == hi0, "R9 high byte held during conversion", r, hi0);
        rd(2'd3, r); chk(r == lo0, "R9 low byte held during conversion", r, lo0);
      end
      @(negedge clk);
      rd(2'd0, r);
    end
    chk(n == 11 * (d + 1), mid_retrigger ? "R8 busy length with retrigger" : "R2 busy length",
        n, 11 * (d + 1));
    chk(r[1] == 1'b1, "R3 done set at end", r[1], 1);
    chk(irq == ie, "R4 irq follows enable", irq, ie);
    rd(2'd2, r); chk(r == exp_hi(v, lj), lj ? "R6 left high byte" : "R5 right high byte", r, exp_hi(v, lj));
    rd(2'd3, r); chk(r == exp_lo(v, lj), lj ? "R6 left low byte" : "R5 right low byte", r, exp_lo(v, lj));
    if (src == 2'b10) begin
      idle(6); rd(2'd0, r);
      chk(r[0] == 1'b0, "R7 held level does not restart", r[0], 0);
      ext_start = 1'b0; idle(4);
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd2417));
    rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    tmr3_ovf = 1'b0; tmr2_ovf = 1'b0; ext_start = 1'b0; vin = '0;
    idle(3); rst = 1'b0; idle(1);

    // R10 reset state
    rd(2'd0, r); chk(r == 8'h00, "R10 control after reset", r, 0);
    rd(2'd1, r); chk(r == 8'h00, "R10 divider after reset", r, 0);
    rd(2'd2, r); chk(r == 8'h00, "R10 result high after reset", r, 0);
    rd(2'd3, r); chk(r == 8'h00, "R10 result low after reset", r, 0);
    chk(irq == 1'b0, "R10 irq after reset", irq, 0);

    // directed extremes
    conv(2'b00, 0, 10'h3FF, 1'b0, 1'b1, 1'b0);
    conv(2'b00, 3, 10'h000, 1'b1, 1'b0, 1'b0);
    conv(2'b01, 15, 10'h200, 1'b1, 1'b1, 1'b0);
    conv(2'b10, 2, 10'h155, 1'b0, 1'b1, 1'b0);

    // R3 done flag: write 1 keeps it, write 0 clears it
    wr(2'd0, 8'h06);
    rd(2'd0, r); chk(r[1] == 1'b1, "R3 write 1 keeps done", r[1], 1);
    chk(irq == 1'b1, "R4 irq with enable and done", irq, 1);
    wr(2'd0, 8'h04);
    rd(2'd0, r); chk(r[1] == 1'b0, "R3 write 0 clears done", r[1], 0);
    chk(irq == 1'b0, "R4 irq drops with done", irq, 0);

    // R1 non-selected sources are ignored (mode 01 selected)
    wr(2'd0, 8'h10);
    tmr2_ovf = 1'b1; @(negedge clk); tmr2_ovf = 1'b0;
    ext_start = 1'b1; idle(5); ext_start = 1'b0;
    wr(2'd0, 8'h13);
    idle(3);
    rd(2'd0, r); chk(r[0] == 1'b0, "R1 other sources ignored in timer mode", r[0], 0);
    // R1 software mode ignores timers
    wr(2'd0, 8'h00);
    tmr3_ovf = 1'b1; tmr2_ovf = 1'b1; @(negedge clk); tmr3_ovf = 1'b0; tmr2_ovf = 1'b0;
    idle(3);
    rd(2'd0, r); chk(r[0] == 1'b0, "R1 timers ignored in software mode", r[0], 0);

    // R8 retriggers during busy
    conv(2'b01, 2, 10'h2AA, 1'b0, 1'b0, 1'b1);
    conv(2'b11, 1, 10'h0F0, 1'b1, 1'b0, 1'b1);
    conv(2'b00, 4, 10'h001, 1'b0, 1'b1, 1'b1);

    // constrained random mix
    for (int k = 0; k < 24; k++) begin
      conv(2'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
           RES_W'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule